// File: doc/BRIEF.md
# Transmit Packet Priority Multiplexer

This block shares one streaming transmit port among five packet sources: a register block that returns completions, two descriptor fetch engines and two DMA engines (one issuing reads, one issuing writes). Each source holds a whole transaction packet before it asks for the port. A packet is a header of three or four dwords, then an optional alignment dword, then zero or more data dwords. The multiplexer picks one source by fixed class priority and passes that packet through untouched from its first word to its last. It only changes source between packets.

Completions take precedence over every request, so they can overtake requests that are still waiting. The two descriptor fetchers share a priority class and take turns. A source takes part in arbitration only when it signals that a complete packet is buffered. This lets a granted packet stream without gaps that the sender would otherwise insert. The downstream sink may still apply back-pressure through its ready signal. The output then pauses in step with ready, and no word is lost or repeated.

Source index is fixed: 0 carries completions, 1 and 2 are the descriptor fetchers, 3 is the DMA read engine and 4 is the DMA write engine. Per-source buses are packed, with source i in slice i.

Top module: `txpkt_prio_mux`

## Requirements
- R1: Out of reset, with no source holding a full packet, `m_valid` is 0 and every bit of `s_ready` is 0.
- R2: A source is eligible only when its `s_full`, `s_valid` and `s_sop` bits are all 1. A source that is valid but not full is never selected.
- R3: Among eligible sources the order is index 0 (completions) first, then the descriptor class (indices 1 and 2), then index 3 (DMA read), then index 4 (DMA write).
- R4: When both descriptor sources are eligible together, the one not served most recently wins. After reset, index 1 wins a tie.
- R5: Once a source's first word appears on the output, that source keeps the port until its end-of-packet word is accepted (`m_valid`, `m_ready` and `m_eop` all 1). No other source's word is interleaved.
- R6: `m_data`, `m_sop` and `m_eop` equal the selected source's slice, and `m_valid` equals that source's `s_valid`.
- R7: `s_ready` is one-hot or zero. Only the selected source's bit may be 1, and only while `m_ready` is 1.
- R8: While `m_valid` is 1 and `m_ready` is 0, the output word stays unchanged on the next cycle. Every source word is delivered exactly once.
- R9: From the first word of a packet until its end-of-packet word is accepted, `m_valid` stays 1 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 5 | Per-source word valid |
| s_full | input | 5 | Per-source flag: a complete packet is buffered |
| s_sop | input | 5 | Per-source first-word marker |
| s_eop | input | 5 | Per-source last-word marker |
| s_data | input | 5*DW | Per-source data word, source i in bits [i*DW +: DW] |
| s_ready | output | 5 | Per-source accept |
| m_valid | output | 1 | Output word valid |
| m_sop | output | 1 | Output first-word marker |
| m_eop | output | 1 | Output last-word marker |
| m_data | output | DW | Output data word |
| m_ready | input | 1 | Sink accept |

## Verification
The bench tries single sources on their own first, which confirms that packets pass through unaltered. It then tries sources that arrive on the same cycle, which separates the class order from arrival order, and paired descriptor packets, which show whether turns alternate. A completion that arrives during a DMA packet shows whether a packet is broken up or only overtaken at its boundary. A source that is valid but withholds its full flag confirms that the flag alone gates eligibility. A final phase with an irregular ready pattern under heavy load tells correct stalling apart from dropped or repeated words.

// File: rtl/txpkt_prio_mux.sv
module txpkt_prio_mux #(
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [4:0]     s_valid,
  input  logic [4:0]     s_full,
  input  logic [4:0]     s_sop,
  input  logic [4:0]     s_eop,
  input  logic [5*DW-1:0] s_data,
  output logic [4:0]     s_ready,
  output logic           m_valid,
  output logic           m_sop,
  output logic           m_eop,
  output logic [DW-1:0]  m_data,
  input  logic           m_ready
);
  localparam int NS = 5;

  logic       busy;
  logic [2:0] owner;
  logic       last_d2;
  logic [2:0] pick;
  logic [2:0] cur;
  logic       any_req, active, end_hs;

  wire [NS-1:0] req = s_full & s_valid & s_sop;

  always_comb begin
    pick = 3'd4;
    if (req[0])                 pick = 3'd0;
    else if (req[1] && req[2])  pick = last_d2 ? 3'd1 : 3'd2;
    else if (req[1])            pick = 3'd1;
    else if (req[2])            pick = 3'd2;
    else if (req[3])            pick = 3'd3;
  end

  assign any_req = |req;
  assign cur     = busy ? owner : pick;
  assign active  = busy | any_req;
  assign m_valid = active & s_valid[cur];
  assign m_sop   = s_sop[cur];
  assign m_eop   = s_eop[cur];
  assign m_data  = s_data[cur*DW +: DW];
  assign s_ready = (active && m_ready) ? (NS'(1) << cur) : '0;
  assign end_hs  = m_valid & m_ready & m_eop;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      owner   <= 3'd0;
      last_d2 <= 1'b1;
    end else if (!busy && any_req) begin
      owner <= pick;
      if (pick == 3'd1) last_d2 <= 1'b0;
      if (pick == 3'd2) last_d2 <= 1'b1;
      if (!end_hs) busy <= 1'b1;
    end else if (busy && end_hs) begin
      busy <= 1'b0;
    end
  end

  // R7
  ready_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_ready) && (|s_ready -> m_ready));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sop) && $stable(m_eop)));

  // R5
  owner_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !end_hs) |=> (busy && $stable(owner)));

  // R9
  no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> m_valid);

  // R2
  eligible_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && m_valid) |-> (s_full[cur] && s_sop[cur]));
endmodule

// File: tb/txpkt_prio_mux_test.sv
module txpkt_prio_mux_test;
  localparam int DW = 32;
  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] s_valid, s_full, s_sop, s_eop, s_ready;
  logic [5*DW-1:0] s_data;
  logic m_valid, m_sop, m_eop, m_ready;
  logic [DW-1:0] m_data;

  int vectors = 0, errors = 0;
  int avail[5], pkt[5], widx[5];
  bit nofull[5];
  int injected = 0, delivered = 0;
  bit mbusy, mlast2;
  int mowner;

  always #2 clk = ~clk;

  txpkt_prio_mux #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_full(s_full), .s_sop(s_sop),
    .s_eop(s_eop), .s_data(s_data), .s_ready(s_ready), .m_valid(m_valid),
    .m_sop(m_sop), .m_eop(m_eop), .m_data(m_data), .m_ready(m_ready));

  function automatic int plen(int i, int k);
    return 3 + ((i * 7 + k * 5) % 7);
  endfunction

  function automatic logic [DW-1:0] word(int i, int k, int w);
    return {4'(i), 12'(k), 16'(w)};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic add(int i, int n);
    avail[i] += n;
    injected += n;
  endtask

  task automatic drive(int c);
    for (int i = 0; i < 5; i++) begin
      s_valid[i] = avail[i] > 0;
      s_full[i]  = (avail[i] > 0) && !nofull[i];
      s_sop[i]   = widx[i] == 0;
      s_eop[i]   = widx[i] == plen(i, pkt[i]) - 1;
      s_data[i*DW +: DW] = word(i, pkt[i], widx[i]);
    end
    m_ready = (c < 400) ? 1'b1 : ((c % 7 != 3) && (c % 11 != 5));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) begin avail[i] = 0; pkt[i] = 0; widx[i] = 0; nofull[i] = 0; end
    mbusy = 0; mlast2 = 1; mowner = 0;
    drive(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: idle after reset
    chk(m_valid == 1'b0, "R1 m_valid", 64'(m_valid), 64'd0);
    chk(s_ready == 5'd0, "R1 s_ready", 64'(s_ready), 64'd0);
    for (int c = 0; c < 1400; c++) begin
      int mcur, mpick;
      bit anyr, act, ev, fire;
      bit [4:0] er;
      @(negedge clk);
      if (c == 10) add(4, 1);
      if (c == 30) begin add(3, 1); add(4, 1); end              // R3: read before write
      if (c == 60) begin add(1, 2); add(2, 2); end              // R4: desc alternate
      if (c == 100) add(4, 2);
      if (c == 103) add(0, 1);                                  // R5: cpl waits for boundary
      if (c == 150) begin nofull[3] = 1; add(3, 1); add(4, 1); end // R2: not full, skipped
      if (c == 175) nofull[3] = 0;
      if (c == 200) for (int i = 0; i < 5; i++) add(i, 2);      // R3 all at once
      if (c == 400) for (int i = 0; i < 5; i++) add(i, 3);      // R8 stalls under load
      if (c == 420) add(0, 2);
      drive(c);
      #1;
      anyr = 0; mpick = 4;
      for (int i = 0; i < 5; i++) er[i] = s_full[i] && s_valid[i] && s_sop[i];
      anyr = |er;
      if (er[0]) mpick = 0;
      else if (er[1] && er[2]) mpick = mlast2 ? 1 : 2;
      else if (er[1]) mpick = 1;
      else if (er[2]) mpick = 2;
      else if (er[3]) mpick = 3;
      mcur = mbusy ? mowner : mpick;
      act = mbusy || anyr;
      ev = act && s_valid[mcur];
      chk(m_valid == ev, "R6 m_valid", 64'(m_valid), 64'(ev));
      if (mbusy) chk(m_valid == 1'b1, "R9 gap", 64'(m_valid), 64'd1);
      if (ev) begin
        chk(m_data == s_data[mcur*DW +: DW], "R3 m_data", 64'(m_data), 64'(s_data[mcur*DW +: DW]));
        chk({m_sop, m_eop} == {s_sop[mcur], s_eop[mcur]}, "R5 framing",
            64'({m_sop, m_eop}), 64'({s_sop[mcur], s_eop[mcur]}));
      end
      chk(s_ready == ((act && m_ready) ? 5'(1 << mcur) : 5'd0), "R7 s_ready",
          64'(s_ready), 64'((act && m_ready) ? 5'(1 << mcur) : 5'd0));
      fire = ev && m_ready;
      if (!mbusy && anyr) begin
        mowner = mpick;
        if (mpick == 1) mlast2 = 0;
        if (mpick == 2) mlast2 = 1;
        if (!(fire && s_eop[mcur])) mbusy = 1;
      end else if (mbusy && fire && s_eop[mcur]) mbusy = 0;
      if (fire) begin
        if (s_eop[mcur]) begin
          widx[mcur] = 0; pkt[mcur]++; avail[mcur]--; delivered++;
        end else widx[mcur]++;
      end
    end
    // R8: every packet delivered once
    chk(delivered == injected, "R8 packet count", 64'(delivered), 64'(injected));
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule